// File: doc/BRIEF.md
# Multi-Channel Output-Compare Timer

A general-purpose timing block for eight output pins. A shared 16-bit up-counter advances on ticks of a bus-clock prescaler. Each channel owns a 16-bit compare value. When the counter steps onto that value, the channel raises its event flag. It also drives its pin high or low, or flips it, as its action field says.

Channel 7 has two extra roles. Its match can force a chosen group of pins to chosen levels, and this forced level wins over a pin's own action. Its compare value can also serve as the counter's period limit. In that mode the counter counts 0..limit, rests on the limit for a single bus cycle and restarts at zero. This gives a period of limit × prescale + 1 bus cycles.

Software reaches the block through a single-cycle register write port with a combinational read-back.

Top module: `oct_cmp_timer`

## Requirements
- R1: After reset, every register reads 0, the counter is 0, and all pins and flags are low.
- R2: With the enable bit set, the counter advances by one every 2^p bus cycles, where p is the 3-bit prescale field. It wraps from 0xFFFF to 0 when running freely.
- R3: While the enable bit is clear, the counter and all pins keep their values.
- R4: A channel whose mode bit is 1 registers a match in the same clock edge at which the counter takes its compare value. A channel whose mode bit is 0 never sets its flag or moves its pin.
- R5: The action field of channel n sits at bits 2n+1:2n of the action register. On a match, 01 inverts the pin, 10 drives it low, 11 drives it high, and 00 leaves it untouched.
- R6: A match sets the channel's flag. Writing 1 to a flag bit clears it, and writing 0 leaves it as it is.
- R7: On a channel-7 match, every pin whose override-mask bit is 1 takes its override-level bit. This takes priority over that channel's own action at the same edge.
- R8: Writing override-mask bits, for channels whose action is 00, changes no pin and no flag.
- R9: With wrap-on-channel-7 enabled and a nonzero channel-7 value L, the counter runs 0..L. It holds L for exactly one bus cycle and then goes to 0. The period is L × 2^p + 1 bus cycles.
- R10: With wrap-on-channel-7 enabled and a channel-7 value of 0, the counter runs freely.
- R11: Register map:
  - Addresses 0–7 hold the compare value of channel n.
  - Address 8 is control: bit 0 enable, bits 3:1 prescale, bit 4 wrap-on-channel-7.
  - Address 9 holds the mode bits, one per channel.
  - Address 10 holds the action fields.
  - Address 11 holds the override mask in bits 7:0 and the override levels in bits 15:8.
  - Address 12 holds the flags.
  - Address 13 is the counter; it is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Register address for write and read-back |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| cmp_pin | output | 8 | Compare output pins, one per channel |
| cmp_flag | output | 8 | Per-channel match flags |

## Verification
The hardest case to reach from the ports is the single bus cycle in which the counter rests on the channel-7 limit before it restarts. It is invisible unless the counter is sampled on every cycle. The bench therefore reads the counter register at each falling edge while wrap mode runs with a prescale of 2. It measures the length of every run of equal values and the spacing between successive returns to zero. Priority between the override and a channel's own action is reached by giving one channel a set action and a masked low override on the same compare value, so that both act at the same edge.

// File: rtl/oct_timer_pkg.sv
package oct_timer_pkg;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned N_CH  = 8;
  localparam int unsigned PS_W  = 3;
  localparam int unsigned AW    = 4;

  // register addresses; compare values occupy 0 .. N_CH-1
  localparam logic [3:0] A_CTRL  = 4'd8;
  localparam logic [3:0] A_MODE  = 4'd9;
  localparam logic [3:0] A_ACT   = 4'd10;
  localparam logic [3:0] A_OVR   = 4'd11;
  localparam logic [3:0] A_FLAG  = 4'd12;
  localparam logic [3:0] A_COUNT = 4'd13;

  typedef enum logic [1:0] {
    PA_NONE   = 2'b00,
    PA_INVERT = 2'b01,
    PA_LOW    = 2'b10,
    PA_HIGH   = 2'b11
  } pin_act_e;
endpackage

// File: rtl/oct_prescaler.sv
module oct_prescaler #(
  parameter int unsigned PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [PS_W-1:0] sel,
  output logic            tick
);
  localparam int unsigned DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] acc_q, acc_d, lim;

  always_comb begin
    lim   = ~({DIV_W{1'b1}} << sel);
    tick  = run && ((acc_q & lim) == lim);
    acc_d = acc_q;
    if (run) begin
      if (restart || tick) acc_d = '0;
      else                 acc_d = acc_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/oct_counter.sv
module oct_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             wrap_en,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] nxt,
  output logic             load,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    // the limit value lasts one bus cycle, independent of the prescaler
    wrap  = run && wrap_en && (top != '0) && (cnt_q == top);
    load  = wrap || tick;
    nxt   = wrap ? '0 : cnt_q + CNT_W'(1);
    cnt_d = load ? nxt : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/oct_chan.sv
module oct_chan
  import oct_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] nxt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             oc_en,
  input  logic [1:0]       act,
  input  logic             ovr_fire,
  input  logic             ovr_mask,
  input  logic             ovr_val,
  input  logic             flag_clr,
  output logic             hit,
  output logic             pin,
  output logic             flag
);
  logic pin_q, pin_d, flag_q, flag_d;

  always_comb begin
    hit   = load && oc_en && (nxt == cmp);
    pin_d = pin_q;
    if (ovr_fire && ovr_mask) begin
      pin_d = ovr_val;
    end else if (hit) begin
      case (pin_act_e'(act))
        PA_INVERT: pin_d = ~pin_q;
        PA_LOW:    pin_d = 1'b0;
        PA_HIGH:   pin_d = 1'b1;
        default:   pin_d = pin_q;
      endcase
    end
    flag_d = hit || (flag_q && !flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      pin_q  <= pin_d;
      flag_q <= flag_d;
    end
  end

  assign pin  = pin_q;
  assign flag = flag_q;
endmodule

// File: rtl/oct_regfile.sv
module oct_regfile
  import oct_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CH  = 8,
  parameter int unsigned PS_W  = 3,
  parameter int unsigned AW    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [AW-1:0]              addr,
  input  logic [CNT_W-1:0]           wdata,
  input  logic [CNT_W-1:0]           cnt,
  input  logic [N_CH-1:0]            flags,
  output logic [N_CH-1:0][CNT_W-1:0] cmp,
  output logic                       run,
  output logic [PS_W-1:0]            ps_sel,
  output logic                       wrap_en,
  output logic [N_CH-1:0]            mode,
  output logic [2*N_CH-1:0]          act,
  output logic [N_CH-1:0]            ovr_mask,
  output logic [N_CH-1:0]            ovr_val,
  output logic [N_CH-1:0]            flag_clr,
  output logic [CNT_W-1:0]           rdata
);
  localparam int unsigned CTL_W = PS_W + 2;
  localparam int unsigned SEL_W = $clog2(N_CH);

  logic [N_CH-1:0][CNT_W-1:0] cmp_q, cmp_d;
  logic [CTL_W-1:0]  ctl_q, ctl_d;
  logic [N_CH-1:0]   mode_q, mode_d, mask_q, mask_d, val_q, val_d;
  logic [2*N_CH-1:0] act_q, act_d;

  always_comb begin
    cmp_d    = cmp_q;
    ctl_d    = ctl_q;
    mode_d   = mode_q;
    act_d    = act_q;
    mask_d   = mask_q;
    val_d    = val_q;
    flag_clr = '0;
    for (int i = 0; i < int'(N_CH); i++) begin
      if (wr && (addr == AW'(i))) cmp_d[i] = wdata;
    end
    if (wr) begin
      case (addr)
        A_CTRL: ctl_d  = wdata[CTL_W-1:0];
        A_MODE: mode_d = wdata[N_CH-1:0];
        A_ACT:  act_d  = wdata[2*N_CH-1:0];
        A_OVR: begin
          mask_d = wdata[N_CH-1:0];
          val_d  = wdata[2*N_CH-1:N_CH];
        end
        A_FLAG: flag_clr = wdata[N_CH-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      ctl_q  <= '0;
      mode_q <= '0;
      act_q  <= '0;
      mask_q <= '0;
      val_q  <= '0;
    end else begin
      cmp_q  <= cmp_d;
      ctl_q  <= ctl_d;
      mode_q <= mode_d;
      act_q  <= act_d;
      mask_q <= mask_d;
      val_q  <= val_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr < AW'(N_CH)) begin
      rdata = cmp_q[addr[SEL_W-1:0]];
    end else begin
      case (addr)
        A_CTRL:  rdata = CNT_W'(ctl_q);
        A_MODE:  rdata = CNT_W'(mode_q);
        A_ACT:   rdata = CNT_W'(act_q);
        A_OVR:   rdata = CNT_W'({val_q, mask_q});
        A_FLAG:  rdata = CNT_W'(flags);
        A_COUNT: rdata = cnt;
        default: rdata = '0;
      endcase
    end
  end

  assign cmp      = cmp_q;
  assign run      = ctl_q[0];
  assign ps_sel   = ctl_q[PS_W:1];
  assign wrap_en  = ctl_q[PS_W+1];
  assign mode     = mode_q;
  assign act      = act_q;
  assign ovr_mask = mask_q;
  assign ovr_val  = val_q;
endmodule

// File: rtl/oct_cmp_timer.sv
module oct_cmp_timer
  import oct_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CH  = 8,
  parameter int unsigned PS_W  = 3,
  parameter int unsigned AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic [N_CH-1:0]  cmp_pin,
  output logic [N_CH-1:0]  cmp_flag
);
  localparam int unsigned TOP_CH = N_CH - 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic [N_CH-1:0][CNT_W-1:0] cmp_all;
  logic                       run, wrap_en, tick, load, wrap, ovr_fire;
  logic [PS_W-1:0]            ps_sel;
  logic [N_CH-1:0]            mode, ovr_mask, ovr_val, flag_clr, hit;
  logic [2*N_CH-1:0]          act;
  logic [CNT_W-1:0]           cnt, nxt, top_val;

  oct_regfile #(.CNT_W(CNT_W), .N_CH(N_CH), .PS_W(PS_W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .cnt(cnt), .flags(cmp_flag), .cmp(cmp_all), .run(run), .ps_sel(ps_sel),
    .wrap_en(wrap_en), .mode(mode), .act(act), .ovr_mask(ovr_mask), .ovr_val(ovr_val),
    .flag_clr(flag_clr), .rdata(bus_rdata)
  );

  assign top_val = cmp_all[TOP_CH];

  oct_prescaler #(.PS_W(PS_W)) u_psc (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .restart(wrap), .sel(ps_sel), .tick(tick)
  );

  oct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .tick(tick), .wrap_en(wrap_en),
    .top(top_val), .cnt(cnt), .nxt(nxt), .load(load), .wrap(wrap)
  );

  // channel-7 match, formed here so no channel feeds its own input
  assign ovr_fire = load && mode[TOP_CH] && (nxt == top_val);

  for (genvar g = 0; g < int'(N_CH); g++) begin : g_ch
    oct_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_sync_n), .load(load), .nxt(nxt), .cmp(cmp_all[g]),
      .oc_en(mode[g]), .act(act[2*g+1:2*g]), .ovr_fire(ovr_fire),
      .ovr_mask(ovr_mask[g]), .ovr_val(ovr_val[g]), .flag_clr(flag_clr[g]),
      .hit(hit[g]), .pin(cmp_pin[g]), .flag(cmp_flag[g])
    );
  end
endmodule

// File: rtl/oct_timer_chk.sv
module oct_timer_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CH  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             wrap_en,
  input logic             tick,
  input logic [CNT_W-1:0] top,
  input logic [CNT_W-1:0] cnt,
  input logic             ovr_fire,
  input logic [N_CH-1:0]  mask,
  input logic [N_CH-1:0]  val,
  input logic [N_CH-1:0]  hit,
  input logic [N_CH-1:0]  pins,
  input logic [N_CH-1:0]  flags
);
  logic at_top;
  assign at_top = run && wrap_en && (top != '0) && (cnt == top);

  // R3
  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(cnt) && $stable(pins)));

  // R9
  a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    at_top |=> (cnt == '0));

  // R2
  a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !at_top) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

  // R2
  a_r2_idle_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !at_top) |=> $stable(cnt));

  for (genvar g = 0; g < int'(N_CH); g++) begin : g_chk
    // R6
    a_r6_flag_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |=> flags[g]);
    // R7
    a_r7_override_level: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_fire && mask[g]) |=> (pins[g] == $past(val[g])));
  end
endmodule

bind oct_cmp_timer oct_timer_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .run(run), .wrap_en(wrap_en), .tick(tick),
  .top(top_val), .cnt(cnt), .ovr_fire(ovr_fire), .mask(ovr_mask), .val(ovr_val),
  .hit(hit), .pins(cmp_pin), .flags(cmp_flag)
);

// File: tb/oct_cmp_timer_test.sv
module oct_cmp_timer_test;
  localparam logic [3:0] R_CTRL = 4'd8, R_MODE = 4'd9, R_ACT = 4'd10,
                         R_OVR = 4'd11, R_FLAG = 4'd12, R_CNT = 4'd13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = R_CNT;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  cmp_pin, cmp_flag;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  oct_cmp_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_pin(cmp_pin), .cmp_flag(cmp_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_wr = 1'b0;
    bus_addr = R_CNT;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_addr = R_CNT;
    #1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = R_CNT;
    #1;
  endtask

  task automatic wait_count(input logic [15:0] v);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      #1;
      if (bus_rdata == v) return;
    end
    chk(1'b0, "wait_count", int'(bus_rdata), int'(v));
  endtask

  // follows the counter every cycle; checks step value, run length and period
  task automatic observe(input int cyc, input int div, input int top, input bit wrap,
                         input string req);
    logic [15:0] prev, cur, exp_n;
    int run_len = 1, since0 = 0;
    bit started = 1'b0, seen0 = 1'b0;
    bus_addr = R_CNT;
    @(negedge clk);
    #1 prev = bus_rdata;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      #1 cur = bus_rdata;
      if (seen0) since0++;
      if (cur == prev) begin
        run_len++;
      end else begin
        exp_n = (wrap && prev == 16'(top)) ? 16'd0 : prev + 16'd1;
        chk(cur == exp_n, req, int'(cur), int'(exp_n));
        if (started)
          chk(run_len == ((wrap && prev == 16'(top)) ? 1 : div), req, run_len,
              (wrap && prev == 16'(top)) ? 1 : div);
        started = 1'b1;
        run_len = 1;
        if (wrap && cur == 16'd0) begin
          if (seen0) chk(since0 == top * div + 1, req, since0, top * div + 1);
          seen0 = 1'b1;
          since0 = 0;
        end
        prev = cur;
      end
    end
  endtask

  task automatic t_reset_state();
    logic [15:0] d;
    do_reset();
    chk(cmp_pin == 8'h00, "R1 pins", int'(cmp_pin), 0);
    chk(cmp_flag == 8'h00, "R1 flags", int'(cmp_flag), 0);
    for (int a = 0; a < 14; a++) begin
      rd(4'(a), d);
      chk(d == 16'h0, "R1 register", int'(d), 0);
    end
    wr(4'd3, 16'hBEEF);
    rd(4'd3, d);
    chk(d == 16'hBEEF, "R11 compare readback", int'(d), 16'hBEEF);
    wr(R_ACT, 16'hA5A5);
    rd(R_ACT, d);
    chk(d == 16'hA5A5, "R11 action readback", int'(d), 16'hA5A5);
    wr(R_CNT, 16'h1234);
    rd(R_CNT, d);
    chk(d == 16'h0000, "R11 counter read-only", int'(d), 0);
  endtask

  task automatic t_prescale();
    do_reset();
    wr(R_CTRL, 16'h0001);
    observe(20, 1, 0, 1'b0, "R2 div1");
    wr(R_CTRL, 16'h0007);
    observe(100, 8, 0, 1'b0, "R2 div8");
  endtask

  task automatic t_match_actions();
    logic [15:0] c1, c2;
    logic [7:0]  p1;
    do_reset();
    for (int c = 0; c < 5; c++) wr(4'(c), 16'd5);
    wr(4'd7, 16'd8);
    wr(R_MODE, 16'h008F);
    wr(R_ACT, 16'h033D);
    wr(R_CTRL, 16'h0011);
    wait_count(16'd4);
    chk(cmp_pin[4:0] == 5'b00000, "R4 before match", int'(cmp_pin), 0);
    @(negedge clk);
    #1;
    chk(bus_rdata == 16'd5, "R4 count", int'(bus_rdata), 5);
    chk(cmp_pin[4:0] == 5'b00111, "R5 first match pins", int'(cmp_pin[4:0]), 7);
    chk(cmp_flag[4:0] == 5'b01111, "R4 flags, mode 0 channel silent",
        int'(cmp_flag[4:0]), 15);
    wr(R_ACT, 16'h0339);
    wait_count(16'd4);
    chk(cmp_pin[4:0] == 5'b00111, "R5 hold between matches", int'(cmp_pin[4:0]), 7);
    @(negedge clk);
    #1;
    chk(cmp_pin[4:0] == 5'b00100, "R5 invert and drive low", int'(cmp_pin[4:0]), 4);
    wr(R_CTRL, 16'h0010);
    rd(R_CNT, c1);
    p1 = cmp_pin;
    repeat (10) @(negedge clk);
    #1;
    rd(R_CNT, c2);
    chk(c2 == c1, "R3 counter holds", int'(c2), int'(c1));
    chk(cmp_pin == p1, "R3 pins hold", int'(cmp_pin), int'(p1));
    chk(cmp_flag == 8'h8F, "R6 flags latched", int'(cmp_flag), 8'h8F);
    wr(R_FLAG, 16'h0000);
    chk(cmp_flag == 8'h8F, "R6 write 0 keeps", int'(cmp_flag), 8'h8F);
    wr(R_FLAG, 16'h0001);
    chk(cmp_flag == 8'h8E, "R6 write 1 clears", int'(cmp_flag), 8'h8E);
  endtask

  task automatic t_override();
    do_reset();
    wr(4'd0, 16'd6);
    wr(4'd2, 16'd6);
    wr(4'd7, 16'd6);
    wr(R_MODE, 16'h0085);
    wr(R_ACT, 16'h0033);
    wr(R_OVR, 16'h0203);
    wr(R_CTRL, 16'h0001);
    wait_count(16'd5);
    chk(cmp_pin[2:0] == 3'b000, "R7 before match", int'(cmp_pin), 0);
    @(negedge clk);
    #1;
    chk(cmp_pin[2:0] == 3'b110, "R7 override priority", int'(cmp_pin[2:0]), 6);
    chk(cmp_flag == 8'h85, "R7 flags", int'(cmp_flag), 8'h85);
  endtask

  task automatic t_mask_only();
    do_reset();
    for (int c = 0; c < 8; c++) wr(4'(c), 16'h1000);
    wr(R_MODE, 16'h007F);
    wr(R_CTRL, 16'h0001);
    wr(R_OVR, 16'hFFFF);
    repeat (5) @(negedge clk);
    #1;
    chk(cmp_pin == 8'h00, "R8 pins after mask write", int'(cmp_pin), 0);
    chk(cmp_flag == 8'h00, "R8 flags after mask write", int'(cmp_flag), 0);
  endtask

  task automatic t_wrap();
    logic [15:0] d;
    do_reset();
    wr(4'd7, 16'd5);
    wr(R_CTRL, 16'h0013);
    observe(80, 2, 5, 1'b1, "R9 div2");
    wr(R_CTRL, 16'h0011);
    observe(40, 1, 5, 1'b1, "R9 div1");
    do_reset();
    wr(R_CTRL, 16'h0011);
    observe(40, 1, 0, 1'b0, "R10 zero limit");
    rd(R_CNT, d);
    chk(d >= 16'd30, "R10 counter passes", int'(d), 30);
  endtask

  initial begin
    t_reset_state();
    t_prescale();
    t_match_actions();
    t_override();
    t_mask_only();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule